// File: doc/BRIEF.md
# Interrupt Enable and Event Flag Register

This block is the interrupt control register of a small microcontroller core. It is eight bits wide and holds a master enable, an enable for the peripheral group, an enable for each of three local sources, and an event flag for each of those sources. The three sources are a timer overflow pulse, an external interrupt pulse, and a change on the upper nibble of an 8-bit input port. The block combines the enables and flags into one interrupt request for the core.

Software reaches the register through a simple bus that has an address, write data, a write strobe and combinational read data. The register sits at one low offset, and that offset is repeated in all four banks. Flags are set by hardware and cleared only by software. The port-change flag is driven by a comparison between the synchronized upper port pins and a snapshot of those pins. The snapshot is refreshed only when the port register is read.

Top module: `intctl_reg`

## Requirements
- R1: Register bits, MSB first, are: master enable (7), peripheral enable (6), timer enable (5), pin enable (4), port-change enable (3), timer flag (2), pin flag (1), port-change flag (0). A read at low offset 0x0B returns them. A read at any other low offset returns 0x00.
- R2: Address bits 8:7 select the bank and are ignored. The register answers at 0x00B, 0x08B, 0x10B and 0x18B.
- R3: A write at the register offset loads all eight bits from the write data. A write elsewhere, or no write, leaves the enable bits unchanged.
- R4: A timer pulse sets bit 2 and an external pulse sets bit 1. This happens even when every enable bit is 0.
- R5: A flag holds its value until software writes a 0 to it. Writing 1 to a flag sets it.
- R6: If a hardware set and a software write of 0 reach the same flag in the same cycle, the flag ends up 1.
- R7: Bit 0 sets while any synchronized port bit 7:4 differs from the snapshot. While the difference lasts, writing 0 to bit 0 does not clear it.
- R8: A pulse on the port-read strobe loads the snapshot with the synchronized port bits 7:4. After that, a write of 0 clears bit 0 and the bit stays 0. Changes on port bits 3:0 never set bit 0.
- R9: Port pins go through a two-flop synchronizer. A change driven before clock edge 1 sets bit 0 at edge 3 and not earlier.
- R10: The request output is 1 exactly when the master enable is 1 and one of these holds: timer enable AND timer flag, pin enable AND pin flag, port-change enable AND port-change flag, or peripheral enable AND the peripheral request input.
- R11: After reset, bits 7:1 read 0 and bit 0 is undefined (either value is accepted). The snapshot and the synchronizer reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Register address, bank in bits 8:7 |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, combinational |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_pulse | input | 1 | External interrupt pulse |
| port_pins | input | 8 | Raw port input pins |
| port_rd | input | 1 | Port register read strobe |
| periph_req | input | 1 | Combined peripheral-group request |
| irq | output | 1 | Interrupt request to the core |

## Verification
The hardest state to reach is a port-change flag that keeps setting itself after software tries to clear it, followed by its release. The bench steps the upper port nibble and samples bit 0 at each synchronizer stage. It then writes 0 while the port still differs from the snapshot, strobes a port read, and writes 0 again to show that the clear now holds. Separately, the bench sweeps all 256 register values against both levels of the peripheral request, and it lands a timer pulse in the same cycle as a clearing write.

// File: rtl/intctl_pkg.sv
package intctl_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_SRC = 3;
  // source index order matches flag/enable bit order: timer, pin, port change
  localparam int SRC_TMR = 2;
  localparam int SRC_PIN = 1;
  localparam int SRC_CHG = 0;

  typedef struct packed {
    logic               gie;
    logic               pen;
    logic [NUM_SRC-1:0] src_en;
    logic [NUM_SRC-1:0] src_fl;
  } ctl_t;
endpackage

// File: rtl/intctl_sync.sv
module intctl_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/intctl_mismatch.sv
module intctl_mismatch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_s,
  input  logic         reload,
  output logic         mismatch
);
  logic [W-1:0] snap_q;
  logic [W-1:0] snap_d;

  always_comb begin
    snap_d = snap_q;
    if (reload) snap_d = pins_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  assign mismatch = (pins_s != snap_q);

  AST_SNAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (snap_q == $past(pins_s))); // R8
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(snap_q)); // R8
endmodule

// File: rtl/intctl_flag.sv
module intctl_flag #(
  parameter bit HAS_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_wr,
  input  logic sw_val,
  output logic flag
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (sw_wr)  flag_d = sw_val;
    if (hw_set) flag_d = 1'b1;
  end

  generate
    if (HAS_RST) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
      end
    end else begin : g_norst
      always_ff @(posedge clk) begin
        flag_q <= flag_d;
      end
    end
  endgenerate

  assign flag = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag); // R6
  AST_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !sw_wr) |=> flag); // R5
endmodule

// File: rtl/intctl_reg.sv
module intctl_reg
  import intctl_pkg::*;
#(
  parameter int          ADDR_W      = 9,
  parameter int          OFS_W       = 7,
  parameter logic [6:0]  REG_OFS     = 7'h0B,
  parameter int          PORT_W      = 8,
  parameter int          CHG_LO      = 4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              tmr_ovf,
  input  logic              ext_pulse,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              port_rd,
  input  logic              periph_req,
  output logic              irq
);
  localparam int CHG_W = PORT_W - CHG_LO;

  logic             hit;
  logic             wr_hit;
  logic [CHG_W-1:0] chg_s;
  logic             chg_mis;
  logic [NUM_SRC-1:0] hw_set;
  logic [NUM_SRC-1:0] fl;
  logic             gie_q, pen_q;
  logic [NUM_SRC-1:0] en_q;
  logic             gie_d, pen_d;
  logic [NUM_SRC-1:0] en_d;
  ctl_t             cur;
  logic             unused_ok;

  assign unused_ok = ^{bus_addr[ADDR_W-1:OFS_W], port_pins[CHG_LO-1:0]};

  // bank bits above OFS_W are ignored: the offset is mirrored in every bank
  assign hit    = (bus_addr[OFS_W-1:0] == REG_OFS[OFS_W-1:0]);
  assign wr_hit = hit && bus_we;

  intctl_sync #(.W(CHG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(port_pins[PORT_W-1:CHG_LO]), .q(chg_s)
  );

  intctl_mismatch #(.W(CHG_W)) u_mis (
    .clk(clk), .rst_n(rst_n), .pins_s(chg_s), .reload(port_rd), .mismatch(chg_mis)
  );

  always_comb begin
    hw_set          = '0;
    hw_set[SRC_TMR] = tmr_ovf;
    hw_set[SRC_PIN] = ext_pulse;
    hw_set[SRC_CHG] = chg_mis;
  end

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      intctl_flag #(.HAS_RST(i != SRC_CHG)) u_flag (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set[i]),
        .sw_wr(wr_hit), .sw_val(bus_wdata[i]), .flag(fl[i])
      );
    end
  endgenerate

  // enable bits: next state
  always_comb begin
    gie_d = gie_q;
    pen_d = pen_q;
    en_d  = en_q;
    if (wr_hit) begin
      gie_d = bus_wdata[REG_W-1];
      pen_d = bus_wdata[REG_W-2];
      en_d  = bus_wdata[2*NUM_SRC-1:NUM_SRC];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      pen_q <= 1'b0;
      en_q  <= '0;
    end else begin
      gie_q <= gie_d;
      pen_q <= pen_d;
      en_q  <= en_d;
    end
  end

  always_comb begin
    cur.gie    = gie_q;
    cur.pen    = pen_q;
    cur.src_en = en_q;
    cur.src_fl = fl;
  end

  assign bus_rdata = hit ? cur : '0;
  assign irq = gie_q && ((|(en_q & fl)) || (pen_q && periph_req));

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq); // R10
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(gie_q) && $stable(pen_q) && $stable(en_q))); // R3
  AST_OFF_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (bus_rdata == '0)); // R1
  AST_TMR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> bus_rdata[2] || !hit); // R4
endmodule

// File: tb/intctl_reg_bench.sv
module intctl_reg_bench;
  localparam int PERIOD = 10;
  localparam logic [8:0] OFS = 9'h00B;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_we;
  logic [7:0] bus_rdata;
  logic       tmr_ovf, ext_pulse, port_rd, periph_req;
  logic [7:0] port_pins;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  intctl_reg u_intctl_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf),
    .ext_pulse(ext_pulse), .port_pins(port_pins), .port_rd(port_rd),
    .periph_req(periph_req), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [8:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  function automatic logic exp_irq(input logic [7:0] v, input logic pr);
    return v[7] && ((v[5] && v[2]) || (v[4] && v[1]) || (v[3] && v[0]) || (v[6] && pr));
  endfunction

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = OFS; bus_wdata = '0; bus_we = 1'b0;
    tmr_ovf = 0; ext_pulse = 0; port_rd = 0; periph_req = 0; port_pins = '0;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R11: bits 7:1 zero, bit 0 either value
    bus_addr = OFS; #1;
    chk("R11 reset bits 7:1", bus_rdata & 8'hFE, 8'h00);
    chk("R11 irq at reset", {7'b0, irq}, 8'h00);
    wr(OFS, 8'h00);
    rd("R11 cleared", OFS, 8'h00);

    // R3 R5 R10: sweep every register value against both peripheral request levels
    for (int v = 0; v < 256; v++) begin
      for (int pr = 0; pr < 2; pr++) begin
        wr(OFS, v[7:0]);
        periph_req = pr[0];
        #1;
        rd("R3 R5 write/readback", OFS, v[7:0]);
        chk("R10 irq", {7'b0, irq}, {7'b0, exp_irq(v[7:0], pr[0])});
      end
    end
    periph_req = 0;
    wr(OFS, 8'h00);

    // R2: every bank mirrors the offset
    for (int b = 0; b < 4; b++) begin
      wr({b[1:0], OFS[6:0]}, 8'h50 + 8'(b));
      rd("R2 bank mirror", {b[1:0] + 2'd1, OFS[6:0]}, 8'h50 + 8'(b));
    end
    // R1 R3: other offsets read zero and do not write
    wr(9'h00C, 8'hFF);
    rd("R1 other offset reads 0", 9'h00C, 8'h00);
    rd("R3 other offset no write", OFS, 8'h53);
    wr(OFS, 8'h00);

    // R4: flags set with every enable off
    tmr_ovf = 1; cycles(1); tmr_ovf = 0;
    rd("R4 timer flag", OFS, 8'h04);
    ext_pulse = 1; cycles(1); ext_pulse = 0;
    rd("R4 pin flag", OFS, 8'h06);
    chk("R4 irq stays low", {7'b0, irq}, 8'h00);
    // R5: flags hold, clear only by writing 0
    cycles(5);
    rd("R5 flags hold", OFS, 8'h06);
    wr(OFS, 8'h02);
    rd("R5 clear timer only", OFS, 8'h02);
    wr(OFS, 8'h00);
    rd("R5 clear pin", OFS, 8'h00);

    // R6: set beats clear in the same cycle
    wr(OFS, 8'h04);
    bus_addr = OFS; bus_wdata = 8'h00; bus_we = 1; tmr_ovf = 1;
    cycles(1);
    bus_we = 0; tmr_ovf = 0;
    rd("R6 set wins", OFS, 8'h04);
    wr(OFS, 8'h00);

    // R10: source enable with flag raises irq
    wr(OFS, 8'hA0);
    tmr_ovf = 1; cycles(1); tmr_ovf = 0; #1;
    chk("R10 timer irq", {7'b0, irq}, 8'h01);
    wr(OFS, 8'h00);

    // R9: synchronizer latency on the port-change path
    port_pins = 8'hA0;
    cycles(2); #1;
    rd("R9 no flag after two edges", OFS, 8'h00);
    cycles(1); #1;
    rd("R9 flag on third edge", OFS, 8'h01);
    // R7: clear does not stick while mismatch lasts
    wr(OFS, 8'h00);
    rd("R7 flag re-asserts", OFS, 8'h01);
    cycles(3);
    rd("R7 flag persists", OFS, 8'h01);
    // R8: port read reloads snapshot, then clear sticks
    port_rd = 1; cycles(1); port_rd = 0;
    wr(OFS, 8'h00);
    rd("R8 clear after port read", OFS, 8'h00);
    cycles(3);
    rd("R8 clear holds", OFS, 8'h00);
    // R8: low nibble changes never set the flag
    for (int n = 0; n < 16; n++) begin
      port_pins = {4'hA, n[3:0]};
      cycles(3);
      rd("R8 low nibble ignored", OFS, 8'h00);
    end
    // R7 R10: port-change enable drives irq
    wr(OFS, 8'h88);
    port_pins = 8'h30;
    cycles(3); #1;
    chk("R10 port change irq", {7'b0, irq}, 8'h01);
    rd("R7 flag from second change", OFS, 8'h89);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule